// File: doc/BRIEF.md
# Synchronous Burst Memory Core with Selectable Output Latency

This block is a synchronous, 32-bit-wide static memory core made of four byte lanes. Every synchronous input is captured on the rising clock edge: chip enable, address, write data and write controls. The captured command then acts on the array. A write may update a chosen set of byte lanes, or all four lanes at once through a global write that takes priority over the lane selects. Read data leaves the block on a shared data bus, which is modelled here as a data output plus a drive flag that controls an external tri-state buffer.

A static mode input sets the read latency. With `mode_pipe` low, the block runs in flow-through mode: the array output goes straight to the bus in the cycle after the read is captured. With `mode_pipe` high, one more rising-edge register sits in the path. Tie `mode_pipe` high when the pin is not otherwise used, because pipelined operation is the default. Bus turn-off follows single-cycle-deselect rules: a captured deselect or write stops the drive after that same edge, which is one stage sooner than a read delivers its data. The output enable and the sleep input act on the bus at once, with no clock. While sleep is high, the core captures no commands and keeps its contents.

Top module: `burst_sram_core`

## Requirements
- R1: After reset, `dq_drive` is 0 and `dq_o` is 0.
- R2: A captured write with `gw` high updates all four byte lanes of the addressed word, whatever the values of `bwe` and `bsel`.
- R3: With `gw` low, `bwe` high and `bsel` non-zero, only the lanes whose `bsel` bit is set are written. Bit i of `bsel` selects `wdata[8i+7:8i]`. With `bwe` high and `bsel` zero, the cycle is a read.
- R4: In flow-through mode (`mode_pipe`=0), a read captured at edge k drives the word on `dq_o` with `dq_drive` high from edge k until edge k+1.
- R5: In pipelined mode (`mode_pipe`=1), a read captured at edge k drives its word after edge k+1, but only if the command captured at edge k+1 is also a read.
- R6: A deselect (`ce` low) captured at an edge turns the bus off after that same edge in either mode. This also cancels a pipelined read that is still waiting.
- R7: A captured write turns the bus off after the edge that captures it.
- R8: `oe_n` high forces `dq_drive` and `dq_o` to 0 without waiting for a clock. When `oe_n` falls, the drive comes back.
- R9: `sleep` high forces the bus off without waiting for a clock. Commands presented while it is high are ignored, and the stored words are kept.
- R10: A read captured one edge after a write to the same address returns the newly written word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low reset of the control registers |
| mode_pipe | input | 1 | Static latency select: 1 pipelined, 0 flow-through |
| ce | input | 1 | Chip enable, registered; low means deselect |
| gw | input | 1 | Global write, all lanes |
| bwe | input | 1 | Byte-write enable |
| bsel | input | 4 | Per-lane write selects |
| addr | input | AW (8) | Word address |
| wdata | input | 32 | Write data |
| oe_n | input | 1 | Asynchronous output enable, active low |
| sleep | input | 1 | Asynchronous sleep request, active high |
| dq_o | output | 32 | Read data toward the shared bus; 0 when not driven |
| dq_drive | output | 1 | High while the block drives the bus |

## Verification
The bench uses the default address width of 8, which gives a 256-word array. Every address the tests use can be written and read back, and lane masks, global-write priority and retention can be observed directly. Both values of `mode_pipe` are exercised. This brings the latency difference and the single-cycle-deselect cancellation of a pending pipelined read within reach, as well as the asynchronous turn-off by `oe_n` and `sleep` in the middle of a cycle.

// File: rtl/bsc_pkg.sv
package bsc_pkg;
  localparam int LANES  = 4;
  localparam int LANE_W = 8;
  localparam int WORD_W = LANES * LANE_W;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;
endpackage

// File: rtl/bsc_in_stage.sv
module bsc_in_stage
  import bsc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce,
  input  logic              gw,
  input  logic              bwe,
  input  logic [LANES-1:0]  bsel,
  input  logic [AW-1:0]     addr,
  input  logic [WORD_W-1:0] wdata,
  input  logic              sleep,
  output op_e               op_q,
  output logic [LANES-1:0]  mask_q,
  output logic [AW-1:0]     addr_q,
  output logic [WORD_W-1:0] wdata_q
);
  logic [LANES-1:0] mask_c;
  op_e              op_c;

  // global write wins over the per-lane selects
  always_comb begin
    mask_c = gw ? {LANES{1'b1}} : (bwe ? bsel : '0);
    if (!ce || sleep)  op_c = OP_IDLE;
    else if (|mask_c)  op_c = OP_WRITE;
    else               op_c = OP_READ;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q    <= OP_IDLE;
      mask_q  <= '0;
      addr_q  <= '0;
      wdata_q <= '0;
    end else begin
      op_q    <= op_c;
      mask_q  <= mask_c;
      addr_q  <= addr;
      wdata_q <= wdata;
    end
  end

  // R9
  sleep_blocks_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sleep |=> (op_q == OP_IDLE));
endmodule

// File: rtl/bsc_array.sv
module bsc_array
  import bsc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  mask,
  input  logic [AW-1:0]     waddr,
  input  logic [WORD_W-1:0] wdata,
  input  logic [AW-1:0]     raddr,
  output logic [WORD_W-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    logic [LANE_W-1:0] lane_mem [DEPTH];

    always_ff @(posedge clk) begin
      if (we && mask[b]) lane_mem[waddr] <= wdata[b*LANE_W +: LANE_W];
    end

    assign rdata[b*LANE_W +: LANE_W] = lane_mem[raddr];

    // R3
    lane_untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && !mask[b] && $past(rst_n)) |=> lane_mem[$past(waddr)] == $past(lane_mem[waddr]));
    // R2
    lane_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (we && mask[b]) |=> lane_mem[$past(waddr)] == $past(wdata[b*LANE_W +: LANE_W]));
  end
endmodule

// File: rtl/bsc_out_stage.sv
module bsc_out_stage
  import bsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  op_e               op_q,
  input  logic [WORD_W-1:0] rdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [WORD_W-1:0] dq_o,
  output logic              dq_drive
);
  logic              rd_now;
  logic              rd_late;
  logic [WORD_W-1:0] pipe_q;
  logic              sync_on;

  assign rd_now = (op_q == OP_READ);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_late <= 1'b0;
      pipe_q  <= '0;
    end else begin
      rd_late <= rd_now;
      if (rd_now) pipe_q <= rdata;
    end
  end

  // turn-off depends only on the newest captured command: one stage early
  always_comb begin
    if (mode_pipe) sync_on = rd_late && rd_now;
    else           sync_on = rd_now;
  end

  assign dq_drive = sync_on && !oe_n && !sleep;
  assign dq_o     = dq_drive ? (mode_pipe ? pipe_q : rdata) : '0;
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
  import bsc_pkg::*;
#(
  parameter int AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_pipe,
  input  logic              ce,
  input  logic              gw,
  input  logic              bwe,
  input  logic [3:0]        bsel,
  input  logic [AW-1:0]     addr,
  input  logic [31:0]       wdata,
  input  logic              oe_n,
  input  logic              sleep,
  output logic [31:0]       dq_o,
  output logic              dq_drive
);
  op_e              op_q;
  logic [LANES-1:0] mask_q;
  logic [AW-1:0]    addr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WORD_W-1:0] rdata;

  bsc_in_stage #(.AW(AW)) u_in (
    .clk(clk), .rst_n(rst_n), .ce(ce), .gw(gw), .bwe(bwe), .bsel(bsel),
    .addr(addr), .wdata(wdata), .sleep(sleep),
    .op_q(op_q), .mask_q(mask_q), .addr_q(addr_q), .wdata_q(wdata_q)
  );

  bsc_array #(.AW(AW)) u_mem (
    .clk(clk), .rst_n(rst_n), .we(op_q == OP_WRITE), .mask(mask_q),
    .waddr(addr_q), .wdata(wdata_q), .raddr(addr_q), .rdata(rdata)
  );

  bsc_out_stage u_out (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .op_q(op_q),
    .rdata(rdata), .oe_n(oe_n), .sleep(sleep),
    .dq_o(dq_o), .dq_drive(dq_drive)
  );

  logic port_read;
  assign port_read = ce && !gw && !(bwe && |bsel);

  // R6
  deselect_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!ce) |=> !dq_drive);
  // R7
  write_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ce && !port_read) |=> !dq_drive);
  // R4
  flow_read_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_pipe && port_read && !sleep) |=> (dq_drive || oe_n || sleep));
  // R8
  idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dq_drive |-> (dq_o == '0));
endmodule

// File: tb/sim_burst_sram_core.sv
module sim_burst_sram_core;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_pipe = 1'b1;
  logic        ce = 1'b0, gw = 1'b0, bwe = 1'b0;
  logic [3:0]  bsel = '0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic        oe_n = 1'b0, sleep = 1'b0;
  logic [31:0] dq_o;
  logic        dq_drive;

  int errors = 0;
  int checks = 0;

  always #10 clk = ~clk;

  burst_sram_core #(.AW(8)) u0 (
    .clk(clk), .rst_n(rst_n), .mode_pipe(mode_pipe), .ce(ce), .gw(gw),
    .bwe(bwe), .bsel(bsel), .addr(addr), .wdata(wdata), .oe_n(oe_n),
    .sleep(sleep), .dq_o(dq_o), .dq_drive(dq_drive)
  );

  typedef struct packed {
    logic        ce, gw, bwe;
    logic [3:0]  sel;
    logic [7:0]  a;
    logic [31:0] d;
    logic        en;
    logic [31:0] q;
  } vec_t;

  // pipelined mode; expectation sampled after the edge capturing the row
  localparam vec_t TBL [14] = '{
    '{1,1,0,4'h0,8'h01,32'h11111111,0,32'h0},        // R2 write
    '{1,1,0,4'h0,8'h02,32'h22222222,0,32'h0},        // R7
    '{1,0,1,4'h1,8'h01,32'hAAAAAAAA,0,32'h0},        // R3 lane 0
    '{1,0,0,4'h0,8'h01,32'h0,0,32'h0},               // R5 not yet
    '{1,0,0,4'h0,8'h02,32'h0,1,32'h111111AA},        // R5 R3
    '{0,0,0,4'h0,8'h00,32'h0,0,32'h0},               // R6 cancels
    '{1,0,1,4'h0,8'h01,32'h0,0,32'h0},               // R3 bwe no sel = read
    '{1,0,0,4'h0,8'h02,32'h0,1,32'h111111AA},        // R5
    '{1,1,1,4'h1,8'h02,32'h33333333,0,32'h0},        // R7 R2 gw overrides
    '{1,0,0,4'h0,8'h02,32'h0,0,32'h0},
    '{0,0,0,4'h0,8'h00,32'h0,0,32'h0},               // R6
    '{1,0,0,4'h0,8'h02,32'h0,0,32'h0},
    '{1,0,0,4'h0,8'h01,32'h0,1,32'h33333333},        // R2 R5
    '{0,0,0,4'h0,8'h00,32'h0,0,32'h0}                // R6
  };

  task automatic check(input string req, input logic en_e, input logic [31:0] q_e);
    checks++;
    if (dq_drive !== en_e || dq_o !== q_e) begin
      errors++;
      $display("FAIL %s: drive=%0b dq=%08h expected drive=%0b dq=%08h",
               req, dq_drive, dq_o, en_e, q_e);
    end
  endtask

  task automatic step(input logic c, input logic g, input logic b, input logic [3:0] s,
                      input logic [7:0] a, input logic [31:0] d);
    ce = c; gw = g; bwe = b; bsel = s; addr = a; wdata = d;
    @(posedge clk);
    #5;
  endtask

  task automatic idle();
    step(0, 0, 0, 4'h0, 8'h00, 32'h0);
  endtask

  initial begin
    for (int i = 0; i < 200000; i++) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1 reset", 1'b0, 32'h0);
    rst_n = 1'b1;
    idle();
    check("R1 after release", 1'b0, 32'h0);

    for (int i = 0; i < 14; i++) begin
      step(TBL[i].ce, TBL[i].gw, TBL[i].bwe, TBL[i].sel, TBL[i].a, TBL[i].d);
      check($sformatf("R5/R6/R7/R2/R3 row %0d", i), TBL[i].en, TBL[i].q);
    end

    // flow-through directed tests
    idle();
    mode_pipe = 1'b0;
    idle();
    step(1, 1, 0, 4'h0, 8'h05, 32'h55AA55AA);
    check("R7 flow write", 1'b0, 32'h0);
    step(1, 0, 1, 4'hA, 8'h05, 32'hFFFFFFFF);
    check("R7 flow byte write", 1'b0, 32'h0);
    step(1, 0, 0, 4'h0, 8'h05, 32'h0);
    check("R4 R3 flow read lanes 1,3", 1'b1, 32'hFFAAFFAA);
    idle();
    check("R6 flow deselect", 1'b0, 32'h0);
    step(1, 1, 0, 4'h0, 8'h07, 32'h12345678);
    step(1, 0, 0, 4'h0, 8'h07, 32'h0);
    check("R10 R4 write then read", 1'b1, 32'h12345678);

    oe_n = 1'b1; #1;
    check("R8 oe_n high", 1'b0, 32'h0);
    oe_n = 1'b0; #1;
    check("R8 oe_n low again", 1'b1, 32'h12345678);
    sleep = 1'b1; #1;
    check("R9 sleep off", 1'b0, 32'h0);
    step(1, 1, 0, 4'h0, 8'h07, 32'hDEADBEEF);
    check("R9 sleep write ignored", 1'b0, 32'h0);
    idle();
    sleep = 1'b0;
    idle();
    step(1, 0, 0, 4'h0, 8'h07, 32'h0);
    check("R9 retained", 1'b1, 32'h12345678);
    step(1, 0, 0, 4'h0, 8'h05, 32'h0);
    check("R4 back-to-back flow read", 1'b1, 32'hFFAAFFAA);
    idle();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule